// File: doc/BRIEF.md
# Three-Pin Edge Capture Unit with Selectable Transfer Request

The unit timestamps edges on three input pins, named X, A and B, against a running PWM counter. Each pin feeds two capture slots. The even slot of a pair takes rising edges and the odd slot takes falling edges, so up to six edges can be recorded in one PWM period. Each slot holds a one-entry FIFO with the counter value and the period number at which the edge was taken. The period number comes from an internal counter that advances on every reload pulse.

A memory-transfer engine unloads the results through a word-addressed read port of twelve words. Reading a slot's value word pops that slot's FIFO. When the slot's transfer enable is set, the same read also clears the slot's capture flag.

The unit raises a read request from one of three selectable sources:
- the FIFO fill state, with the enabled slots combined by AND or by OR;
- the local sync pulse;
- the period reload pulse.

Each pin has an arm control. A pin can run free, capturing every period, or in one-shot mode, taking one capture per slot for each arming.

Top module: `cap_unit`

## Requirements
- R1: During and after reset all capture flags, overflow bits and the request are 0, and every read word returns 0.
- R2: Pin X is bit 0 of `pins_i`, A is bit 1 and B is bit 2. Slot 2p captures rising edges of pin p. Slot 2p+1 captures falling edges of pin p.
- R3: If a new pin level is first sampled at clock edge k, the slot stores the `cnt_i` value present at edge k+2, and its flag is visible after edge k+2.
- R4: The period counter is CYC_W bits wide. It advances by one on each clock edge where `reload_i` is high, and wraps to 0. A capture stores the count held before that edge.
- R5: Read word 2i returns slot i's period stamp, zero-extended. Word 2i+1 returns slot i's value. Words 12 to 15 return 0. Only a read (`rd_en_i`) of word 2i+1 pops slot i.
- R6: A capture sets the slot's flag. A read of word 2i+1 clears flag i only when `dma_en_i[i]` is 1. If a set and a clear meet in the same cycle, the set wins.
- R7: An edge that reaches a full slot is dropped, and the slot's sticky overflow bit is set, unless that slot is popped in the same cycle, in which case the edge is stored. Overflow bits clear while their pin's arm is low.
- R8: Edges on a pin whose `arm_i` bit is low are ignored. With `freerun_i` high a slot keeps capturing. With `freerun_i` low each slot stores at most one capture per high interval of `arm_i`.
- R9: `req_src_i` selects the request source: 00 gives no request, 01 the FIFO fill condition, 10 the sync pulse, 11 the reload pulse.
- R10: With source 01 the request is high when at least one `dma_en_i` bit is set and either any enabled slot is full (`fand_i` = 0) or all enabled slots are full (`fand_i` = 1). With no enable bit set the request is low.
- R11: With source 10 or 11 the selected pulse sets a pending request, which appears on the next cycle. A read of word 11 clears it, and a new pulse in the same cycle wins. Any other source clears the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Asynchronous capture pins (bit 0 X, 1 A, 2 B) |
| cnt_i | input | CNT_W | Running PWM counter |
| sync_i | input | 1 | Local sync pulse (counter matched its compare value) |
| reload_i | input | 1 | Period reload pulse |
| arm_i | input | NUM_PINS | Per-pin capture arm |
| freerun_i | input | NUM_PINS | Per-pin free-run (1) or one-shot (0) |
| dma_en_i | input | 2*NUM_PINS | Per-slot transfer enable |
| fand_i | input | 1 | Fill combine: 1 AND, 0 OR |
| req_src_i | input | 2 | Request source select |
| rd_en_i | input | 1 | Read strobe (pops and clears) |
| rd_addr_i | input | clog2(4*NUM_PINS) | Read word address |
| rd_data_o | output | CNT_W | Read data for `rd_addr_i` |
| dma_req_o | output | 1 | Read request |
| cap_flag_o | output | 2*NUM_PINS | Per-slot capture flags |
| ovf_o | output | 2*NUM_PINS | Per-slot sticky overflow |

## Verification
The bench builds the unit with NUM_PINS = 3, CNT_W = 16 and CYC_W = 3. The narrow period counter lets ten reload pulses show the wrap of the stamp within a short run. The full six-slot read map and its four unused words all fall inside a 4-bit address. Random pin toggles, reads that pop exactly as a new edge lands, mixed one-shot and free-run pins, and changes of source and combine mode reach the drop, pop-and-store and set-beats-clear corners that directed steps alone would miss.

// File: rtl/cap_pkg.sv
package cap_pkg;

    // Request source encoding; the numeric values are part of the interface.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'b00,
        SRC_WMARK  = 2'b01,
        SRC_SYNC   = 2'b10,
        SRC_RELOAD = 2'b11
    } req_src_e;

    // Per-slot control bits held alongside the stored value.
    typedef struct packed {
        logic full;
        logic done;
        logic flag;
        logic ovf;
    } slot_bits_t;

endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
    parameter int NUM_PINS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);

    // Two synchronizing stages plus one history stage per pin.
    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] stable;
        logic [NUM_PINS-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = pins_i;
        sync_d.stable = sync_q.meta;
        sync_d.prev   = sync_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.stable & ~sync_q.prev;
    assign fall_o = ~sync_q.stable & sync_q.prev;

endmodule

// File: rtl/cap_slot.sv
module cap_slot
    import cap_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             freerun_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CYC_W-1:0] cyc_i,
    input  logic             pop_i,
    input  logic             clr_i,
    output logic             full_o,
    output logic             flag_o,
    output logic             ovf_o,
    output logic [CNT_W-1:0] val_o,
    output logic [CYC_W-1:0] stamp_o
);

    typedef struct packed {
        slot_bits_t       bits;
        logic [CNT_W-1:0] val;
        logic [CYC_W-1:0] stamp;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  take;
    logic  room;

    always_comb begin
        slot_d = slot_q;
        take   = arm_i && !slot_q.bits.done && edge_i;
        room   = !slot_q.bits.full || pop_i;

        if (pop_i) slot_d.bits.full = 1'b0;
        if (clr_i) slot_d.bits.flag = 1'b0;

        if (!arm_i) begin
            slot_d.bits.done = 1'b0;
            slot_d.bits.ovf  = 1'b0;
        end else if (take) begin
            if (room) begin
                slot_d.bits.full = 1'b1;
                slot_d.bits.flag = 1'b1;
                slot_d.bits.done = !freerun_i;
                slot_d.val       = cnt_i;
                slot_d.stamp     = cyc_i;
            end else begin
                slot_d.bits.ovf  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign full_o  = slot_q.bits.full;
    assign flag_o  = slot_q.bits.flag;
    assign ovf_o   = slot_q.bits.ovf;
    assign val_o   = slot_q.val;
    assign stamp_o = slot_q.stamp;

endmodule

// File: rtl/cap_req.sv
module cap_req
    import cap_pkg::*;
#(
    parameter int NREG = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  req_src_e        src_i,
    input  logic [NREG-1:0] full_i,
    input  logic [NREG-1:0] de_i,
    input  logic            fand_i,
    input  logic            sync_i,
    input  logic            reload_i,
    input  logic            last_rd_i,
    output logic            req_o
);

    typedef struct packed {
        logic pend;
    } req_state_t;

    req_state_t st_d, st_q;
    logic wm_any, wm_all, wm_one, wm_hit;

    always_comb begin
        wm_any = |de_i;
        wm_all = &(full_i | ~de_i);
        wm_one = |(full_i & de_i);
        wm_hit = wm_any && (fand_i ? wm_all : wm_one);

        st_d = st_q;
        case (src_i)
            SRC_SYNC:   st_d.pend = sync_i   || (st_q.pend && !last_rd_i);
            SRC_RELOAD: st_d.pend = reload_i || (st_q.pend && !last_rd_i);
            default:    st_d.pend = 1'b0;
        endcase

        case (src_i)
            SRC_WMARK:             req_o = wm_hit;
            SRC_SYNC, SRC_RELOAD:  req_o = st_q.pend;
            default:               req_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cap_unit.sv
module cap_unit
    import cap_pkg::*;
#(
    parameter int NUM_PINS = 3,
    parameter int CNT_W    = 16,
    parameter int CYC_W    = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PINS-1:0]             pins_i,
    input  logic [CNT_W-1:0]                cnt_i,
    input  logic                            sync_i,
    input  logic                            reload_i,
    input  logic [NUM_PINS-1:0]             arm_i,
    input  logic [NUM_PINS-1:0]             freerun_i,
    input  logic [2*NUM_PINS-1:0]           dma_en_i,
    input  logic                            fand_i,
    input  logic [1:0]                      req_src_i,
    input  logic                            rd_en_i,
    input  logic [$clog2(4*NUM_PINS)-1:0]   rd_addr_i,
    output logic [CNT_W-1:0]                rd_data_o,
    output logic                            dma_req_o,
    output logic [2*NUM_PINS-1:0]           cap_flag_o,
    output logic [2*NUM_PINS-1:0]           ovf_o
);

    localparam int NREG  = 2 * NUM_PINS;
    localparam int NWORD = 2 * NREG;
    localparam int AW    = $clog2(NWORD);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
    } period_t;

    period_t per_d, per_q;

    logic [NUM_PINS-1:0] rise, fall;
    logic [NREG-1:0]     pop, clr, full;
    logic [CNT_W-1:0]    val_w   [NREG];
    logic [CYC_W-1:0]    stamp_w [NREG];
    logic                last_rd;

    // Period counter.
    always_comb begin
        per_d = per_q;
        if (reload_i) per_d.cyc = per_q.cyc + CYC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_q <= '0;
        else        per_q <= per_d;
    end

    cap_edge_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    // Read decode: value words pop, cycle words do not.
    always_comb begin
        pop = '0;
        clr = '0;
        for (int i = 0; i < NREG; i++) begin
            pop[i] = rd_en_i && (rd_addr_i == AW'(2 * i + 1));
            clr[i] = pop[i] && dma_en_i[i];
        end
        last_rd = rd_en_i && (rd_addr_i == AW'(NWORD - 1));
    end

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam int PIN = g / 2;
        logic edge_sel;

        if (g % 2 == 0) begin : g_rise
            assign edge_sel = rise[PIN];
        end else begin : g_fall
            assign edge_sel = fall[PIN];
        end

        cap_slot #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm_i     (arm_i[PIN]),
            .freerun_i (freerun_i[PIN]),
            .edge_i    (edge_sel),
            .cnt_i     (cnt_i),
            .cyc_i     (per_q.cyc),
            .pop_i     (pop[g]),
            .clr_i     (clr[g]),
            .full_o    (full[g]),
            .flag_o    (cap_flag_o[g]),
            .ovf_o     (ovf_o[g]),
            .val_o     (val_w[g]),
            .stamp_o   (stamp_w[g])
        );
    end

    // Read data mux.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr_i == AW'(2 * i))     rd_data_o = CNT_W'(stamp_w[i]);
            if (rd_addr_i == AW'(2 * i + 1)) rd_data_o = val_w[i];
        end
    end

    cap_req #(.NREG(NREG)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (req_src_e'(req_src_i)),
        .full_i    (full),
        .de_i      (dma_en_i),
        .fand_i    (fand_i),
        .sync_i    (sync_i),
        .reload_i  (reload_i),
        .last_rd_i (last_rd),
        .req_o     (dma_req_o)
    );

endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
    parameter int NUM_PINS = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_PINS-1:0]           arm_i,
    input logic [2*NUM_PINS-1:0]         dma_en_i,
    input logic                          sync_i,
    input logic [1:0]                    req_src_i,
    input logic                          rd_en_i,
    input logic [$clog2(4*NUM_PINS)-1:0] rd_addr_i,
    input logic                          dma_req_o,
    input logic [2*NUM_PINS-1:0]         cap_flag_o,
    input logic [2*NUM_PINS-1:0]         ovf_o
);

    localparam int AW = $clog2(4 * NUM_PINS);

    assert_src_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_src_i == 2'b00) |-> !dma_req_o);

    assert_no_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_src_i == 2'b01 && dma_en_i == '0) |-> !dma_req_o);

    assert_sync_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_src_i == 2'b10 && sync_i) |=> (req_src_i != 2'b10 || dma_req_o));

    for (genvar g = 0; g < 2 * NUM_PINS; g++) begin : g_chk
        assert_flag_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cap_flag_o[g]) |-> $past(arm_i[g / 2]));

        assert_flag_clear_by_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cap_flag_o[g]) |->
                $past(rd_en_i && rd_addr_i == AW'(2 * g + 1) && dma_en_i[g]));

        assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ovf_o[g]) && $past(arm_i[g / 2])) |-> ovf_o[g]);
    end

endmodule

bind cap_unit cap_unit_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .dma_en_i   (dma_en_i),
    .sync_i     (sync_i),
    .req_src_i  (req_src_i),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .dma_req_o  (dma_req_o),
    .cap_flag_o (cap_flag_o),
    .ovf_o      (ovf_o)
);

// File: tb/cap_unit_test.sv
module cap_unit_test;

    localparam int NP = 3;
    localparam int CW = 16;
    localparam int YW = 3;
    localparam int NR = 2 * NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins_i = '0;
    logic [CW-1:0] cnt_i = '0;
    logic          sync_i = 1'b0;
    logic          reload_i = 1'b0;
    logic [NP-1:0] arm_i = '0;
    logic [NP-1:0] freerun_i = '0;
    logic [NR-1:0] dma_en_i = '0;
    logic          fand_i = 1'b0;
    logic [1:0]    req_src_i = 2'b00;
    logic          rd_en_i = 1'b0;
    logic [3:0]    rd_addr_i = 4'd1;
    logic [CW-1:0] rd_data_o;
    logic          dma_req_o;
    logic [NR-1:0] cap_flag_o;
    logic [NR-1:0] ovf_o;

    int  checks = 0;
    int  errors = 0;
    bit  done_run = 0;
    int  nrel = 0;

    always #10 clk = ~clk;
    always @(negedge clk) cnt_i <= cnt_i + 1'b1;

    cap_unit #(.NUM_PINS(NP), .CNT_W(CW), .CYC_W(YW)) uut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .cnt_i(cnt_i),
        .sync_i(sync_i), .reload_i(reload_i), .arm_i(arm_i),
        .freerun_i(freerun_i), .dma_en_i(dma_en_i), .fand_i(fand_i),
        .req_src_i(req_src_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .dma_req_o(dma_req_o),
        .cap_flag_o(cap_flag_o), .ovf_o(ovf_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [NP-1:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
    logic [NR-1:0] m_full = '0, m_done = '0, m_flag = '0, m_ovf = '0;
    logic [CW-1:0] m_val   [NR];
    logic [YW-1:0] m_stamp [NR];
    logic [YW-1:0] m_cyc = '0;
    logic          m_pend = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
            m_full = '0; m_done = '0; m_flag = '0; m_ovf = '0;
            m_cyc = '0; m_pend = 1'b0;
            for (int i = 0; i < NR; i++) begin
                m_val[i] = '0;
                m_stamp[i] = '0;
            end
        end else begin
            for (int i = 0; i < NR; i++) begin
                int  p;
                bit  ev, pp, room;
                p    = i / 2;
                ev   = (i % 2 == 0) ? (m_s2[p] && !m_s3[p]) : (!m_s2[p] && m_s3[p]);
                pp   = rd_en_i && (rd_addr_i == 4'(2 * i + 1));
                room = !m_full[i] || pp;
                if (pp) m_full[i] = 1'b0;
                if (pp && dma_en_i[i]) m_flag[i] = 1'b0;
                if (!arm_i[p]) begin
                    m_done[i] = 1'b0;
                    m_ovf[i]  = 1'b0;
                end else if (ev && !m_done[i]) begin
                    if (room) begin
                        m_full[i]  = 1'b1;
                        m_flag[i]  = 1'b1;
                        m_done[i]  = !freerun_i[p];
                        m_val[i]   = cnt_i;
                        m_stamp[i] = m_cyc;
                    end else begin
                        m_ovf[i] = 1'b1;
                    end
                end
            end
            if (req_src_i[1])
                m_pend = ((req_src_i == 2'b10) ? sync_i : reload_i) ||
                         (m_pend && !(rd_en_i && rd_addr_i == 4'd11));
            else
                m_pend = 1'b0;
            if (reload_i) m_cyc = m_cyc + 1'b1;
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = pins_i;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        #5;
        if (rst_n && !done_run) begin
            logic          wm, ereq;
            logic [CW-1:0] erd;
            wm = (|dma_en_i) && (fand_i ? &(m_full | ~dma_en_i) : |(m_full & dma_en_i));
            if (req_src_i == 2'b01)  ereq = wm;
            else if (req_src_i[1])   ereq = m_pend;
            else                     ereq = 1'b0;
            if (rd_addr_i >= 4'd12)  erd = '0;
            else if (rd_addr_i[0])   erd = m_val[rd_addr_i >> 1];
            else                     erd = CW'(m_stamp[rd_addr_i >> 1]);
            chk("R6 model flags", 32'(cap_flag_o), 32'(m_flag));
            chk("R7 model overflow", 32'(ovf_o), 32'(m_ovf));
            chk("R9 model request", 32'(dma_req_o), 32'(ereq));
            chk("R5 model read data", 32'(rd_data_o), 32'(erd));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pin_set(input int p, input logic v, output logic [CW-1:0] c);
        tick();
        pins_i[p] = v;
        @(posedge clk);
        c = cnt_i;
        tick(); tick(); tick();
    endtask

    task automatic summary();
        done_run = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [CW-1:0] c0, c1, ca, cf, cx, cb, d;
        repeat (3) tick();
        #3;
        chk("R1 reset flags", 32'(cap_flag_o), 0);
        chk("R1 reset overflow", 32'(ovf_o), 0);
        chk("R1 reset request", 32'(dma_req_o), 0);
        chk("R1 reset read word", 32'(rd_data_o), 0);
        tick();
        rst_n = 1'b1;
        arm_i = '1; freerun_i = '1; dma_en_i = 6'b000001; req_src_i = 2'b01;
        repeat (3) tick();

        // R3 latency and R2 mapping on pin X
        pin_set(0, 1'b1, c0);
        #3;
        chk("R3 flag after third edge", 32'(cap_flag_o[0]), 1);
        chk("R2 falling slot untouched by rise", 32'(cap_flag_o[1]), 0);
        chk("R3 stored counter value", 32'(rd_data_o), 32'(c0 + 2));
        chk("R9 fill source request", 32'(dma_req_o), 1);
        tick(); rd_addr_i = 4'd0;
        #3 chk("R4 stamp before any reload", 32'(rd_data_o), 0);

        pin_set(0, 1'b0, c1);
        tick(); rd_addr_i = 4'd3;
        #3;
        chk("R2 falling slot value", 32'(rd_data_o), 32'(c1 + 2));
        chk("R2 falling slot flag", 32'(cap_flag_o[1]), 1);

        // R6 flag clear with and without enable
        tick(); rd_en_i = 1'b1; rd_addr_i = 4'd1;
        tick(); rd_en_i = 1'b0;
        #3;
        chk("R6 enabled read clears flag", 32'(cap_flag_o[0]), 0);
        chk("R9 request drops after pop", 32'(dma_req_o), 0);
        tick(); rd_en_i = 1'b1; rd_addr_i = 4'd3;
        tick(); rd_en_i = 1'b0;
        #3 chk("R6 disabled read keeps flag", 32'(cap_flag_o[1]), 1);

        // R7 overflow on pin A
        pin_set(1, 1'b1, ca);
        pin_set(1, 1'b0, cf);
        pin_set(1, 1'b1, cx);
        #3 chk("R7 overflow set on full slot", 32'(ovf_o[2]), 1);
        tick(); rd_addr_i = 4'd5;
        #3;
        chk("R7 first value kept", 32'(rd_data_o), 32'(ca + 2));
        chk("R7 other slot no overflow", 32'(ovf_o[3]), 0);
        tick(); arm_i[1] = 1'b0;
        tick();
        #3 chk("R7 overflow cleared by disarm", 32'(ovf_o[2]), 0);
        tick(); arm_i[1] = 1'b1;

        // R8 one-shot on pin B
        tick(); freerun_i[2] = 1'b0;
        pin_set(2, 1'b1, cb);
        tick(); rd_en_i = 1'b1; rd_addr_i = 4'd9;
        tick(); rd_en_i = 1'b0;
        pin_set(2, 1'b0, d);
        pin_set(2, 1'b1, d);
        #3;
        chk("R8 one-shot keeps first value", 32'(rd_data_o), 32'(cb + 2));
        chk("R8 one-shot no overflow", 32'(ovf_o[4]), 0);

        // R8 disarmed pin ignored
        tick(); arm_i[0] = 1'b0;
        pin_set(0, 1'b1, d);
        #3 chk("R8 disarmed edge ignored", 32'(cap_flag_o[0]), 0);
        tick(); arm_i[0] = 1'b1;

        // R10 combine modes
        tick(); dma_en_i = 6'b000011; fand_i = 1'b0;
        pin_set(0, 1'b0, d);
        #3 chk("R10 OR of enabled slots", 32'(dma_req_o), 1);
        tick(); fand_i = 1'b1;
        #3 chk("R10 AND of enabled slots", 32'(dma_req_o), 0);
        tick(); dma_en_i = '0; fand_i = 1'b0;
        #3 chk("R10 no enable no request", 32'(dma_req_o), 0);
        tick(); dma_en_i = 6'b000011; req_src_i = 2'b00;
        #3 chk("R9 source off", 32'(dma_req_o), 0);

        // R11 pulse sources
        tick(); req_src_i = 2'b10;
        #3 chk("R11 no pending at switch", 32'(dma_req_o), 0);
        tick(); sync_i = 1'b1;
        tick(); sync_i = 1'b0;
        #3 chk("R11 sync sets request", 32'(dma_req_o), 1);
        tick(); tick();
        #3 chk("R11 request held", 32'(dma_req_o), 1);
        tick(); rd_en_i = 1'b1; rd_addr_i = 4'd11;
        tick(); rd_en_i = 1'b0;
        #3 chk("R11 last word clears request", 32'(dma_req_o), 0);
        tick(); req_src_i = 2'b11; sync_i = 1'b1;
        tick(); sync_i = 1'b0;
        #3 chk("R11 sync ignored on reload source", 32'(dma_req_o), 0);
        tick(); reload_i = 1'b1; nrel++;
        tick(); reload_i = 1'b0;
        #3 chk("R11 reload sets request", 32'(dma_req_o), 1);

        // R4 period counter wrap
        for (int k = 0; k < 9; k++) begin
            tick(); reload_i = 1'b1; nrel++;
            tick(); reload_i = 1'b0;
        end
        pin_set(0, 1'b1, d);
        tick(); rd_addr_i = 4'd0;
        #3 chk("R4 wrapped period stamp", 32'(rd_data_o), 32'(nrel % 8));

        // R5 unmapped word and non-popping stamp read
        tick(); rd_addr_i = 4'd13;
        #3 chk("R5 unmapped word reads zero", 32'(rd_data_o), 0);
        tick(); req_src_i = 2'b01; dma_en_i = 6'b000001; rd_en_i = 1'b1; rd_addr_i = 4'd0;
        tick(); rd_en_i = 1'b0;
        #3 chk("R5 stamp read does not pop", 32'(dma_req_o), 1);

        // Random phase, compared against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            int pi;
            tick();
            pi = $urandom_range(NP - 1);
            if ($urandom_range(5) == 0) pins_i[pi] = ~pins_i[pi];
            if ($urandom_range(80) == 0) arm_i[pi] = ~arm_i[pi];
            if ($urandom_range(120) == 0) freerun_i[pi] = ~freerun_i[pi];
            if ($urandom_range(60) == 0) dma_en_i = NR'($urandom);
            if ($urandom_range(90) == 0) fand_i = ~fand_i;
            if ($urandom_range(150) == 0) req_src_i = 2'($urandom);
            sync_i   = ($urandom_range(15) == 0);
            reload_i = ($urandom_range(15) == 0);
            rd_en_i  = ($urandom_range(2) == 0);
            rd_addr_i = 4'($urandom);
        end
        tick(); rd_en_i = 1'b0;
        tick();
        summary();
    end

endmodule